// File: doc/BRIEF.md
# Two-Slot Bundle Operand Fetch and Writeback

This block supplies source operands to a two-slot execution bundle and accepts the results back. The first slot is a fused multiply-add unit, the second an add unit; neither is part of this block. It holds a general register file of 32-bit words and three forwarding latches: a stage value, the value most recently handed over by the multiply-add slot, and the most recent add result.

Each read request names the slot that is reading and carries one selector per source plus a 64-bit bundle constant. A selector has a 3-bit kind in its top bits and a 6-bit field below it. The kind picks a register, a zero, a right-shifted slice of the bundle constant, or one of the forwarding latches. Operands are registered and appear one cycle after the request.

A writeback names the slot that produced the result, a destination selector and the data. A multiply-add result always lands in the stage latch. An add result makes the forwarding pair rotate: the multiply-add latch takes the stage value and the add latch takes the result. Selectors that cannot be served raise a per-source or destination error flag.

Top module: `bundle_operand_fetch`

## Requirements
- R1: A selector of kind 1 returns register `field` (selector value 64+n for register n) as the operand in the cycle after the request, and reflects any earlier completed writeback to it.
- R2: A read issued in the same cycle as a writeback to the same register returns the value that register held before that writeback.
- R3: A selector of kind 3 returns bits 31:0 of the bundle constant shifted right by `field` places, for every shift from 0 to 63.
- R4: A selector of kind 4, and the all-zero selector, return 0 and raise no error.
- R5: A selector of kind 5 returns 0 when the multiply-add slot reads (slot input 0) and returns the stage latch when the add slot reads (slot input 1).
- R6: A selector of kind 6 returns the multiply-add forwarding latch and a selector of kind 7 returns the add forwarding latch, for either reading slot.
- R7: Every multiply-add writeback loads its data into the stage latch, whatever its destination.
- R8: An add writeback loads the previous stage value into the multiply-add latch and its data into the add latch, and leaves the stage latch unchanged.
- R9: A destination selector of 0 discards the result: no register changes and no destination error is raised; the latch updates of R7 and R8 still occur.
- R10: A source selector of kind 2, of kind 0 with a nonzero field, or of kind 1 naming a register at or above the register count returns 0 and sets that source's error bit alongside the operand.
- R11: A destination selector that is neither 0 nor a legal register changes no register and raises the destination error for exactly the cycle after the writeback; the latch updates still occur.
- R12: Reset, synchronous and active high, clears every register, all three latches, the operand outputs, the valid flag and both error outputs.
- R13: The operand valid flag is high exactly in the cycle after a read request; without a request the operands hold and the source errors are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | Read request |
| rd_slot_add | input | 1 | Reading slot: 0 multiply-add, 1 add |
| rd_sel | input | NSRC x 9 | Source selectors: kind in bits 8:6, field in bits 5:0 |
| bundle_const | input | 64 | Bundle constant for kind-3 sources |
| wb_valid | input | 1 | Writeback request |
| wb_slot_add | input | 1 | Producing slot: 0 multiply-add, 1 add |
| wb_dest | input | 9 | Destination selector, same layout as sources |
| wb_data | input | 32 | Result data |
| opnd_valid | output | 1 | Operands valid |
| opnd | output | NSRC x 32 | Registered operands |
| src_err | output | NSRC | Per-source error bits |
| dst_err | output | 1 | Destination error pulse |

## Verification
A corrupted forwarding latch reaches the ports on the first read of kind 5, 6 or 7 that follows it, one cycle after that request, so the stimulus reads every latch right after each writeback that should have moved it. A wrong register write, including one leaked from a discarded or illegal destination, appears only when that register is next read, so register 0 and the written registers are read back after those writebacks. Ordering faults between read and write show up in the very cycle that both happen together.

// File: rtl/opf_pkg.sv
package opf_pkg;

  typedef enum logic [2:0] {
    SK_NONE  = 3'd0,
    SK_REG   = 3'd1,
    SK_UNIF  = 3'd2,
    SK_CONST = 3'd3,
    SK_ZERO  = 3'd4,
    SK_STAGE = 3'd5,
    SK_PFMA  = 3'd6,
    SK_PADD  = 3'd7
  } src_kind_e;

  localparam int KIND_W = 3;

endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int NREG = 64,
  parameter int DW   = 32,
  parameter int NRD  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][IW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/opf_pass_latches.sv
module opf_pass_latches #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic          from_add,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] stage_q,
  output logic [DW-1:0] fma_q,
  output logic [DW-1:0] add_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      fma_q   <= '0;
      add_q   <= '0;
    end else if (fire) begin
      if (from_add) begin
        fma_q <= stage_q;
        add_q <= data;
      end else begin
        stage_q <= data;
      end
    end
  end

endmodule

// File: rtl/opf_src_decode.sv
module opf_src_decode
  import opf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int CW   = 64,
  parameter int FW   = 6,
  parameter int NREG = 64,
  localparam int IW  = $clog2(NREG),
  localparam int SELW = KIND_W + FW
) (
  input  logic [SELW-1:0] sel,
  input  logic            is_add,
  input  logic [CW-1:0]   konst,
  input  logic [DW-1:0]   rf_val,
  input  logic [DW-1:0]   stage_v,
  input  logic [DW-1:0]   fma_v,
  input  logic [DW-1:0]   add_v,
  output logic [IW-1:0]   rf_idx,
  output logic [DW-1:0]   val,
  output logic            err
);

  src_kind_e      kind;
  logic [FW-1:0]  field;
  logic           idx_bad;

  assign kind   = src_kind_e'(sel[SELW-1:FW]);
  assign field  = sel[FW-1:0];
  assign rf_idx = field[IW-1:0];

  if (NREG < (1 << FW)) begin : g_chk
    assign idx_bad = (int'(field) >= NREG);
  end else begin : g_nochk
    assign idx_bad = 1'b0;
  end

  always_comb begin
    val = '0;
    err = 1'b0;
    unique case (kind)
      SK_NONE:  err = (field != '0);
      SK_REG: begin
        if (idx_bad) err = 1'b1;
        else         val = rf_val;
      end
      SK_UNIF:  err = 1'b1;
      SK_CONST: val = DW'(konst >> field);
      SK_ZERO:  val = '0;
      SK_STAGE: val = is_add ? stage_v : '0;
      SK_PFMA:  val = fma_v;
      SK_PADD:  val = add_v;
      default:  err = 1'b1;
    endcase
  end

endmodule

// File: rtl/bundle_operand_fetch.sv
module bundle_operand_fetch
  import opf_pkg::*;
#(
  parameter int NREG = 64,
  parameter int DW   = 32,
  parameter int CW   = 64,
  parameter int FW   = 6,
  parameter int NSRC = 2,
  localparam int IW   = $clog2(NREG),
  localparam int SELW = KIND_W + FW
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_valid,
  input  logic                        rd_slot_add,
  input  logic [NSRC-1:0][SELW-1:0]   rd_sel,
  input  logic [CW-1:0]               bundle_const,
  input  logic                        wb_valid,
  input  logic                        wb_slot_add,
  input  logic [SELW-1:0]             wb_dest,
  input  logic [DW-1:0]               wb_data,
  output logic                        opnd_valid,
  output logic [NSRC-1:0][DW-1:0]     opnd,
  output logic [NSRC-1:0]             src_err,
  output logic                        dst_err
);

  logic [NSRC-1:0][IW-1:0] rf_raddr;
  logic [NSRC-1:0][DW-1:0] rf_rdata;
  logic [NSRC-1:0][DW-1:0] dec_val;
  logic [NSRC-1:0]         dec_err;
  logic [DW-1:0]           stage_t, pass_fma, pass_add;

  src_kind_e     dkind;
  logic [FW-1:0] dfield;
  logic          d_idx_bad;
  logic          d_is_reg;
  logic          d_is_null;
  logic          rf_we;

  assign dkind     = src_kind_e'(wb_dest[SELW-1:FW]);
  assign dfield    = wb_dest[FW-1:0];
  assign d_is_null = (wb_dest == '0);

  if (NREG < (1 << FW)) begin : g_dchk
    assign d_idx_bad = (int'(dfield) >= NREG);
  end else begin : g_dnochk
    assign d_idx_bad = 1'b0;
  end

  assign d_is_reg = (dkind == SK_REG) && !d_idx_bad;
  assign rf_we    = wb_valid && d_is_reg;

  opf_regfile #(.NREG(NREG), .DW(DW), .NRD(NSRC)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (dfield[IW-1:0]),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  opf_pass_latches #(.DW(DW)) u_pass (
    .clk      (clk),
    .rst      (rst),
    .fire     (wb_valid),
    .from_add (wb_slot_add),
    .data     (wb_data),
    .stage_q  (stage_t),
    .fma_q    (pass_fma),
    .add_q    (pass_add)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    opf_src_decode #(.DW(DW), .CW(CW), .FW(FW), .NREG(NREG)) u_dec (
      .sel     (rd_sel[s]),
      .is_add  (rd_slot_add),
      .konst   (bundle_const),
      .rf_val  (rf_rdata[s]),
      .stage_v (stage_t),
      .fma_v   (pass_fma),
      .add_v   (pass_add),
      .rf_idx  (rf_raddr[s]),
      .val     (dec_val[s]),
      .err     (dec_err[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_valid <= 1'b0;
      opnd       <= '0;
      src_err    <= '0;
      dst_err    <= 1'b0;
    end else begin
      opnd_valid <= rd_valid;
      src_err    <= rd_valid ? dec_err : '0;
      if (rd_valid) opnd <= dec_val;
      dst_err    <= wb_valid && !d_is_reg && !d_is_null;
    end
  end

endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
  parameter int NSRC = 2,
  parameter int DW   = 32,
  parameter int SELW = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_valid,
  input logic                    wb_valid,
  input logic                    wb_slot_add,
  input logic [SELW-1:0]         wb_dest,
  input logic [DW-1:0]           wb_data,
  input logic                    opnd_valid,
  input logic [NSRC-1:0][DW-1:0] opnd,
  input logic [NSRC-1:0]         src_err,
  input logic                    dst_err,
  input logic [DW-1:0]           t,
  input logic [DW-1:0]           t0,
  input logic [DW-1:0]           t1
);

  assert_valid_follows_R13: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> opnd_valid);

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> (!opnd_valid && src_err == '0));

  assert_fma_sets_stage_R7: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_slot_add) |=> (t == $past(wb_data)));

  assert_add_rotates_R8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_slot_add) |=> (t0 == $past(t) && t1 == $past(wb_data) && t == $past(t)));

  assert_discard_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_dest == '0) |=> !dst_err);

  assert_dst_err_cause_R11: assert property (@(posedge clk) disable iff (rst)
    !wb_valid |=> !dst_err);

  for (genvar i = 0; i < NSRC; i++) begin : g_err
    assert_err_zero_R10: assert property (@(posedge clk) disable iff (rst)
      src_err[i] |-> (opnd_valid && opnd[i] == '0));
  end

endmodule

bind bundle_operand_fetch opf_checker #(.NSRC(NSRC), .DW(DW), .SELW(SELW)) chk (
  .clk         (clk),
  .rst         (rst),
  .rd_valid    (rd_valid),
  .wb_valid    (wb_valid),
  .wb_slot_add (wb_slot_add),
  .wb_dest     (wb_dest),
  .wb_data     (wb_data),
  .opnd_valid  (opnd_valid),
  .opnd        (opnd),
  .src_err     (src_err),
  .dst_err     (dst_err),
  .t           (stage_t),
  .t0          (pass_fma),
  .t1          (pass_add)
);

// File: tb/bundle_operand_fetch_test.sv
module bundle_operand_fetch_test;

  logic              clk = 1'b0;
  logic              rst;
  logic              rd_valid, rd_slot_add;
  logic [1:0][8:0]   rd_sel;
  logic [63:0]       bundle_const;
  logic              wb_valid, wb_slot_add;
  logic [8:0]        wb_dest;
  logic [31:0]       wb_data;
  logic              opnd_valid;
  logic [1:0][31:0]  opnd;
  logic [1:0]        src_err;
  logic              dst_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bundle_operand_fetch uut (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_slot_add(rd_slot_add),
    .rd_sel(rd_sel), .bundle_const(bundle_const), .wb_valid(wb_valid),
    .wb_slot_add(wb_slot_add), .wb_dest(wb_dest), .wb_data(wb_data),
    .opnd_valid(opnd_valid), .opnd(opnd), .src_err(src_err), .dst_err(dst_err)
  );

  typedef struct packed {
    logic        wen;
    logic        wadd;
    logic [8:0]  wdst;
    logic [31:0] wdat;
    logic        ren;
    logic        radd;
    logic [8:0]  s0;
    logic [8:0]  s1;
    logic [63:0] k;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [1:0]  eerr;
    logic        ewr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,9'd69, 32'h11111111,1'b1,1'b0,9'd69, 9'd320,64'h0,32'h0,32'h0,2'b00,1'b0},
    '{1'b1,1'b1,9'd70, 32'h22222222,1'b1,1'b1,9'd320,9'd69, 64'h0,32'h11111111,32'h11111111,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b0,9'd384,9'd448,64'h0,32'h11111111,32'h22222222,2'b00,1'b0},
    '{1'b1,1'b0,9'd0,  32'h33333333,1'b1,1'b1,9'd70, 9'd320,64'h0,32'h22222222,32'h11111111,2'b00,1'b0},
    '{1'b1,1'b1,9'd0,  32'h44444444,1'b1,1'b1,9'd320,9'd448,64'h0,32'h33333333,32'h22222222,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b0,9'd384,9'd448,64'h0,32'h33333333,32'h44444444,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b0,9'd192,9'd224,64'h0123456789ABCDEF,32'h89ABCDEF,32'h01234567,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b1,9'd255,9'd252,64'hF000000000000001,32'h1,32'hF,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b0,9'd256,9'd0,  64'h0,32'h0,32'h0,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b0,9'd128,9'd5,  64'h0,32'h0,32'h0,2'b11,1'b0},
    '{1'b1,1'b0,9'd128,32'h55555555,1'b1,1'b0,9'd69, 9'd127,64'h0,32'h11111111,32'h0,2'b00,1'b1},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b1,9'd320,9'd64, 64'h0,32'h55555555,32'h0,2'b00,1'b0},
    '{1'b1,1'b0,9'd127,32'hDEADBEEF,1'b1,1'b0,9'd127,9'd0,  64'h0,32'h0,32'h0,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b0,9'd127,9'd384,64'h0,32'hDEADBEEF,32'h33333333,2'b00,1'b0},
    '{1'b1,1'b1,9'd65, 32'hCAFEF00D,1'b0,1'b0,9'd0,  9'd0,  64'h0,32'h0,32'h0,2'b00,1'b0},
    '{1'b0,1'b0,9'd0,  32'h0,       1'b1,1'b1,9'd65, 9'd384,64'h0,32'hCAFEF00D,32'hDEADBEEF,2'b00,1'b0}
  };

  function automatic string tag(int i);
    case (i)
      0:  return "R2 R5 R7";
      1:  return "R1 R5 R8";
      2:  return "R6 R8";
      3:  return "R1 R5 R9";
      4:  return "R6 R7";
      5:  return "R6 R8";
      6:  return "R3";
      7:  return "R3";
      8:  return "R4";
      9:  return "R10";
      10: return "R1 R11";
      11: return "R7 R9 R11";
      12: return "R2";
      13: return "R1 R6";
      14: return "R13";
      default: return "R1 R8";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_valid = 0; rd_slot_add = 0; rd_sel = '0; bundle_const = '0;
    wb_valid = 0; wb_slot_add = 0; wb_dest = '0; wb_data = '0;
  endtask

  task automatic read_one(logic add, logic [8:0] a, logic [8:0] b);
    idle();
    rd_valid = 1; rd_slot_add = add; rd_sel[0] = a; rd_sel[1] = b;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #2;
    // R12: outputs cleared by reset
    check("R12 valid", 32'(opnd_valid), 0);
    check("R12 opnd0", opnd[0], 0);
    check("R12 opnd1", opnd[1], 0);
    check("R12 errs", {29'd0, src_err, dst_err}, 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      idle();
      wb_valid = TBL[i].wen; wb_slot_add = TBL[i].wadd;
      wb_dest = TBL[i].wdst; wb_data = TBL[i].wdat;
      rd_valid = TBL[i].ren; rd_slot_add = TBL[i].radd;
      rd_sel[0] = TBL[i].s0; rd_sel[1] = TBL[i].s1;
      bundle_const = TBL[i].k;
      @(posedge clk); #2;
      check($sformatf("%s R13 valid v%0d", tag(i), i), 32'(opnd_valid), 32'(TBL[i].ren));
      if (TBL[i].ren) begin
        check($sformatf("%s opnd0 v%0d", tag(i), i), opnd[0], TBL[i].e0);
        check($sformatf("%s opnd1 v%0d", tag(i), i), opnd[1], TBL[i].e1);
      end
      check($sformatf("%s R10 srcerr v%0d", tag(i), i), 32'(src_err), 32'(TBL[i].eerr));
      check($sformatf("%s R11 dsterr v%0d", tag(i), i), 32'(dst_err), 32'(TBL[i].ewr));
    end

    // R13: operands hold while no request (last read left CAFEF00D/DEADBEEF)
    idle();
    @(posedge clk); #2;
    check("R13 hold0", opnd[0], 32'hCAFEF00D);
    check("R13 hold1", opnd[1], 32'hDEADBEEF);

    // R12: reset mid-run clears registers and latches
    rst = 1;
    repeat (2) @(posedge clk);
    #2;
    rst = 0;
    read_one(1'b1, 9'd69, 9'd320);
    check("R12 reg5", opnd[0], 0);
    check("R12 stage", opnd[1], 0);
    read_one(1'b0, 9'd384, 9'd448);
    check("R12 t0", opnd[0], 0);
    check("R12 t1", opnd[1], 0);
    read_one(1'b1, 9'd65, 9'd127);
    check("R12 reg1", opnd[0], 0);
    check("R12 reg63", opnd[1], 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule